// File: doc/BRIEF.md
# Input Capture Channel with Edge Prescaler

This block is one timer capture channel. It takes an asynchronous input pin and runs it through a two-stage synchronizer. A run-length filter then accepts a new level only once the input has held it steadily. The filtered signal goes to an edge detector, where software picks which transition counts, rising or falling. A power-of-two edge divider passes only every 1st, 2nd, 4th or 8th selected transition.

Each transition that passes the divider is a capture event. On a capture event the channel copies the free-running timer count into its capture register. It also sets a capture flag. If the flag was already set, the channel sets an overcapture flag to show that a value was lost. Software clears both flags with a single clear strobe. An interrupt line presents the capture flag through an enable mask.

A typical use is measuring the period or duty cycle of a slow external waveform. With the divider set above 1, the cost of service is spread over several input cycles.

Top module: `icap_channel`

## Requirements
- R1: While `rst_ni` is low, `cap_val_o`, `cap_flag_o`, `ovr_flag_o` and `irq_o` are all 0.
- R2: With `edge_sel_i`=0 only rising transitions of the filtered input are counted. With `edge_sel_i`=1 only falling transitions are counted.
- R3: With filtering off (`flt_len_i`=0), a level change of `sig_i` first seen at clock edge k causes a capture at edge k+3. The captured value is the `count_i` value present at that edge.
- R4: For `flt_len_i`=N≥1, the filtered level changes only after N consecutive synchronized samples at the new level. A pulse shorter than N cycles causes no capture. A stable change first seen at edge k is captured at edge k+2+max(N,1).
- R5: `psc_sel_i` encodes the divider: 0 gives every edge, 1 every 2nd edge, 2 every 4th edge and 3 every 8th edge.
- R6: Changing `psc_sel_i` or lowering `chan_en_i` clears the internal edge count. The next capture then needs a full divider's worth of new edges.
- R7: While `chan_en_i` is 0 no capture occurs. `cap_val_o` and the flags keep their values.
- R8: A capture sets `cap_flag_o` on the next edge. `flag_clr_i` clears it. When a capture and a clear fall in the same cycle, the flag ends set.
- R9: A capture while `cap_flag_o` is already 1 sets `ovr_flag_o`. `flag_clr_i` clears `ovr_flag_o` unless such a capture happens in the same cycle.
- R10: `irq_o` is high exactly when `cap_flag_o` is high and `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 1 | Channel enable |
| sig_i | input | 1 | Raw asynchronous input |
| count_i | input | CNT_W | Timer count to capture |
| edge_sel_i | input | 1 | 0 rising, 1 falling |
| psc_sel_i | input | 2 | Edge divider select (1/2/4/8) |
| flt_len_i | input | FLT_W | Filter run length, 0 = off |
| flag_clr_i | input | 1 | Clears capture and overcapture flags |
| irq_en_i | input | 1 | Interrupt mask |
| cap_val_o | output | CNT_W | Captured count |
| cap_flag_o | output | 1 | Capture flag |
| ovr_flag_o | output | 1 | Overcapture flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A capture event and a software flag clear can land in the same clock cycle, and that collision decides both flags. The bench provokes it from the known pipeline depth. It raises the input, counts three edges with the filter off, and holds the clear strobe high across exactly the edge where the capture lands. It then judges that the capture flag stays set and that the captured value is the count from that edge. A second pair of captures without a clear checks that the overcapture flag is raised.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    PSC_DIV1 = 2'd0,
    PSC_DIV2 = 2'd1,
    PSC_DIV4 = 2'd2,
    PSC_DIV8 = 2'd3
  } psc_e;

  localparam int EDGE_CNT_W = 3;

  // terminal value of the edge counter for a divider setting
  function automatic logic [EDGE_CNT_W-1:0] psc_last(input psc_e sel);
    logic [EDGE_CNT_W:0] span;
    span = ({{EDGE_CNT_W{1'b0}}, 1'b1} << sel);
    return span[EDGE_CNT_W-1:0] - 1'b1;
  endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_q[i] <= 1'b0;
        end else if (i == 0) begin
          stg_q[i] <= d_i;
        end else begin
          stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic [FLT_W-1:0] len_i,
  output logic             lvl_o
);

  logic             lvl_q, lvl_d;
  logic [FLT_W-1:0] run_q, run_d;
  logic [FLT_W:0]   run_inc;

  assign run_inc = {1'b0, run_q} + 1'b1;

  always_comb begin
    lvl_d = lvl_q;
    run_d = '0;
    if (smp_i != lvl_q) begin
      if (run_inc >= {1'b0, len_i}) begin
        lvl_d = smp_i;
      end else begin
        run_d = run_inc[FLT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/icap_edge_psc.sv
module icap_edge_psc
  import icap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  input  logic edge_sel_i,
  input  psc_e psc_i,
  output logic cap_evt_o
);

  logic                  lvl_d1_q;
  psc_e                  psc_q;
  logic [EDGE_CNT_W-1:0] ecnt_q, ecnt_d;
  logic                  qual, restart, hit;

  assign qual    = en_i & (edge_sel_i ? (~lvl_i & lvl_d1_q) : (lvl_i & ~lvl_d1_q));
  assign restart = ~en_i | (psc_i != psc_q);
  assign hit     = qual & ~restart & (ecnt_q == psc_last(psc_i));

  always_comb begin
    ecnt_d = ecnt_q;
    if (restart) begin
      ecnt_d = '0;
    end else if (qual) begin
      ecnt_d = hit ? '0 : ecnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d1_q <= 1'b0;
      psc_q    <= PSC_DIV1;
      ecnt_q   <= '0;
    end else begin
      lvl_d1_q <= lvl_i;
      psc_q    <= psc_i;
      ecnt_q   <= ecnt_d;
    end
  end

  assign cap_evt_o = hit;

endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_en_i,
  input  logic             sig_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             edge_sel_i,
  input  logic [1:0]       psc_sel_i,
  input  logic [FLT_W-1:0] flt_len_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o,
  output logic             irq_o
);

  logic             sig_sync, sig_filt, cap_evt;
  logic [CNT_W-1:0] cap_val_q, cap_val_d;
  logic             cflag_q, cflag_d, oflag_q, oflag_d;

  icap_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sig_i),
    .q_o    (sig_sync)
  );

  icap_filter #(.FLT_W(FLT_W)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (sig_sync),
    .len_i  (flt_len_i),
    .lvl_o  (sig_filt)
  );

  icap_edge_psc u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (chan_en_i),
    .lvl_i      (sig_filt),
    .edge_sel_i (edge_sel_i),
    .psc_i      (psc_e'(psc_sel_i)),
    .cap_evt_o  (cap_evt)
  );

  always_comb begin
    cap_val_d = cap_evt ? count_i : cap_val_q;
    cflag_d   = cflag_q;
    oflag_d   = oflag_q;
    if (flag_clr_i) begin
      cflag_d = 1'b0;
      oflag_d = 1'b0;
    end
    if (cap_evt) begin
      cflag_d = 1'b1;
      if (cflag_q) oflag_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_val_q <= '0;
      cflag_q   <= 1'b0;
      oflag_q   <= 1'b0;
    end else begin
      cap_val_q <= cap_val_d;
      cflag_q   <= cflag_d;
      oflag_q   <= oflag_d;
    end
  end

  assign cap_val_o  = cap_val_q;
  assign cap_flag_o = cflag_q;
  assign ovr_flag_o = oflag_q;
  assign irq_o      = cflag_q & irq_en_i;

endmodule

// File: rtl/icap_chk.sv
module icap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chan_en_i,
  input logic             cap_evt,
  input logic [CNT_W-1:0] count_i,
  input logic             flag_clr_i,
  input logic             irq_en_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             ovr_flag_o,
  input logic             irq_o
);

  // R3
  cap_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_val_o == $past(count_i));

  // R7
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt |=> $stable(cap_val_o));

  // R7
  off_no_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |-> !cap_evt);

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> cap_flag_o);

  // R8
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !cap_evt) |=> !cap_flag_o && !ovr_flag_o);

  // R9
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && cap_flag_o) |=> ovr_flag_o);

  // R10
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

endmodule

bind icap_channel icap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chan_en_i  (chan_en_i),
  .cap_evt    (cap_evt),
  .count_i    (count_i),
  .flag_clr_i (flag_clr_i),
  .irq_en_i   (irq_en_i),
  .cap_val_o  (cap_val_o),
  .cap_flag_o (cap_flag_o),
  .ovr_flag_o (ovr_flag_o),
  .irq_o      (irq_o)
);

// File: tb/sim_icap_channel.sv
`timescale 1ns/1ps
module sim_icap_channel;

  localparam int CNT_W = 16;
  localparam int FLT_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             chan_en = 1'b0;
  logic             sig = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             edge_sel = 1'b0;
  logic [1:0]       psc = 2'd0;
  logic [FLT_W-1:0] flt = '0;
  logic             clr = 1'b0;
  logic             irq_en = 1'b0;
  logic [CNT_W-1:0] cap_val;
  logic             cap_flag, ovr_flag, irq;

  int total = 0;
  int bad = 0;
  int caps = 0;
  logic [CNT_W-1:0] prev_val = '0;

  always #4 clk = ~clk;

  always @(posedge clk) cnt <= cnt + 1'b1;

  // count captures from changes of the captured value
  always @(posedge clk) begin
    if (cap_val != prev_val) caps = caps + 1;
    prev_val = cap_val;
  end

  icap_channel #(.CNT_W(CNT_W), .FLT_W(FLT_W)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .chan_en_i  (chan_en),
    .sig_i      (sig),
    .count_i    (cnt),
    .edge_sel_i (edge_sel),
    .psc_sel_i  (psc),
    .flt_len_i  (flt),
    .flag_clr_i (clr),
    .irq_en_i   (irq_en),
    .cap_val_o  (cap_val),
    .cap_flag_o (cap_flag),
    .ovr_flag_o (ovr_flag),
    .irq_o      (irq)
  );

  // edge_sel, psc, flt, pulses, expected captures
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{0, 0, 0, 3, 3},
    '{1, 0, 0, 3, 3},
    '{0, 1, 0, 5, 2},
    '{0, 2, 3, 9, 2},
    '{1, 3, 2, 16, 2},
    '{1, 1, 5, 4, 2},
    '{0, 3, 0, 7, 0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    sig = 1'b1; tick(hi);
    sig = 1'b0; tick(lo);
  endtask

  task automatic clear_flags();
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
  endtask

  task automatic restart();
    chan_en = 1'b0; tick(2); chan_en = 1'b1; tick(1);
  endtask

  initial begin
    int c0;
    logic [CNT_W-1:0] v;
    tick(3);
    check("R1 cap_val", 32'(cap_val), 0);
    check("R1 cap_flag", 32'(cap_flag), 0);
    check("R1 ovr_flag", 32'(ovr_flag), 0);
    check("R1 irq", 32'(irq), 0);
    rst_ni = 1'b1;
    tick(2);

    // table: polarity, divider and filter patterns (R2 R5)
    for (int i = 0; i < NV; i++) begin
      edge_sel = VEC[i][0][0];
      psc      = VEC[i][1][1:0];
      flt      = VEC[i][2][FLT_W-1:0];
      restart();
      clear_flags();
      c0 = caps;
      for (int p = 0; p < VEC[i][3]; p++) pulse(12, 12);
      tick(20);
      check($sformatf("R2/R5 vec%0d", i), 32'(caps - c0), 32'(VEC[i][4]));
    end

    // R3 latency without filter
    edge_sel = 1'b0; psc = 2'd0; flt = '0; restart(); clear_flags();
    v = cnt; sig = 1'b1; tick(8);
    check("R3 value", 32'(cap_val), 32'(v + 3));
    sig = 1'b0; tick(10);

    // R4 latency with filter length 4
    flt = 4'd4; tick(2);
    v = cnt; sig = 1'b1; tick(12);
    check("R4 filtered value", 32'(cap_val), 32'(v + 6));
    sig = 1'b0; tick(12);

    // R4 short glitch rejected
    clear_flags(); c0 = caps;
    sig = 1'b1; tick(3); sig = 1'b0; tick(14);
    check("R4 glitch caps", 32'(caps - c0), 0);
    check("R4 glitch flag", 32'(cap_flag), 0);
    flt = '0;

    // R6 divider change restarts edge count
    psc = 2'd2; restart(); c0 = caps;
    for (int p = 0; p < 3; p++) pulse(6, 6);
    psc = 2'd1; tick(2);
    c0 = caps; pulse(6, 6); tick(6);
    check("R6 psc change first", 32'(caps - c0), 0);
    pulse(6, 6); tick(6);
    check("R6 psc change second", 32'(caps - c0), 1);

    // R6 disable restarts edge count
    psc = 2'd2; restart();
    for (int p = 0; p < 2; p++) pulse(6, 6);
    restart(); c0 = caps;
    for (int p = 0; p < 3; p++) pulse(6, 6);
    tick(6);
    check("R6 disable three", 32'(caps - c0), 0);
    pulse(6, 6); tick(6);
    check("R6 disable four", 32'(caps - c0), 1);

    // R7 disabled channel
    psc = 2'd0; chan_en = 1'b0; tick(2); clear_flags(); c0 = caps;
    for (int p = 0; p < 3; p++) pulse(6, 6);
    tick(6);
    check("R7 caps", 32'(caps - c0), 0);
    check("R7 flag", 32'(cap_flag), 0);
    chan_en = 1'b1; tick(2);

    // R8 capture and clear in the same cycle
    clear_flags();
    v = cnt; sig = 1'b1; tick(3);
    clr = 1'b1; tick(1); clr = 1'b0;
    check("R8 set wins flag", 32'(cap_flag), 1);
    check("R8 set wins value", 32'(cap_val), 32'(v + 3));
    check("R9 no ovr after clear", 32'(ovr_flag), 0);
    tick(4); sig = 1'b0; tick(8);
    clear_flags();
    check("R8 clear", 32'(cap_flag), 0);

    // R9 overcapture
    pulse(6, 6); tick(4);
    check("R9 first", 32'(ovr_flag), 0);
    // R10 masking
    irq_en = 1'b0; tick(1);
    check("R10 masked", 32'(irq), 0);
    irq_en = 1'b1; tick(1);
    check("R10 unmasked", 32'(irq), 1);
    pulse(6, 6); tick(4);
    check("R9 second", 32'(ovr_flag), 1);
    clear_flags();
    check("R9 cleared", 32'(ovr_flag), 0);
    check("R10 after clear", 32'(irq), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule